// File: doc/BRIEF.md
# Dual-Width General Register File

This block holds the integer working registers of a 64-bit processor core. There are thirty-one general registers, plus one stack pointer kept apart from them. Two read ports and one write port each take a 5-bit index. Each port also carries a width flag: when it is set, the access uses only the low half of the register. When index 31 appears on a port, its meaning depends on that port's stack flag. With the flag set, index 31 reaches the stack pointer. With the flag clear, it is a constant zero that throws away any write.

Reads are purely combinational and do not bypass a write made in the same cycle. Writes land on the rising clock edge.

A dedicated link-write input stores a return address into register 30 when a call is made. A write to the stack pointer must keep the pointer 16-byte aligned. A misaligned value raises a flag for that cycle and is not stored.

Top module: `gpr_file`

## Requirements
- R1: A full-width write to index 0..30 stores all 64 bits, and a full-width read of that index on the next cycle returns them unchanged.
- R2: A read with the narrow flag set returns bits 31:0 of the selected register in bits 31:0 and zero in bits 63:32.
- R3: A write with the narrow flag set stores bits 31:0 of the write data and clears bits 63:32 of the register.
- R4: Index 31 with the port's stack flag clear reads as zero, and a write to it changes neither the stack pointer nor any general register.
- R5: Index 31 with the stack flag set reads and writes the stack pointer. For indices 0..30 the stack flag has no effect.
- R6: When `link_en` is high, register 30 takes the full 64-bit `link_addr` at the clock edge. This input wins over a data-port write to register 30 in the same cycle.
- R7: A read in the same cycle as a write to the same register returns the old value. The new value appears after the edge.
- R8: A synchronous reset (`rst` high at a clock edge) clears all 31 registers and the stack pointer to zero.
- R9: A stack-pointer write whose value has any of bits 3:0 set drives `sp_misalign` high in that cycle and leaves the stack pointer unchanged. A value with bits 3:0 all zero is stored and leaves the flag low.
- R10: The two read ports select independently, so both can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_sp | input | 1 | Port A: index 31 means stack pointer |
| rd_a_narrow | input | 1 | Port A: 32-bit view |
| rd_a_data | output | 64 | Port A read value |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_sp | input | 1 | Port B: index 31 means stack pointer |
| rd_b_narrow | input | 1 | Port B: 32-bit view |
| rd_b_data | output | 64 | Port B read value |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register index |
| wr_sp | input | 1 | Write port: index 31 means stack pointer |
| wr_narrow | input | 1 | Write port: 32-bit view |
| wr_data | input | 64 | Write port value |
| link_en | input | 1 | Store return address into register 30 |
| link_addr | input | 64 | Return address |
| sp_misalign | output | 1 | Current stack-pointer write is not 16-byte aligned |

## Verification
A table of writes followed by read-backs mixes full and narrow views on both sides. Write data with ones in the upper half separates a narrow write that clears that half from one that keeps it. A narrow read of a full-width value separates masking on read from masking on write. Directed cases pair index 31 with the stack flag set and clear, and check the stack pointer after discarded and misaligned writes. They also read a register in the cycle it is written, put a link write and a data-port write on register 30 together, and reset after the registers have been filled.

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int XLEN     = 64,
  parameter int IW       = 5,
  parameter int NREGS    = 31,
  parameter int LINK_IDX = 30,
  parameter int SP_ALIGN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   rd_a_idx,
  input  logic            rd_a_sp,
  input  logic            rd_a_narrow,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [IW-1:0]   rd_b_idx,
  input  logic            rd_b_sp,
  input  logic            rd_b_narrow,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_sp,
  input  logic            wr_narrow,
  input  logic [XLEN-1:0] wr_data,
  input  logic            link_en,
  input  logic [XLEN-1:0] link_addr,
  output logic            sp_misalign
);
  localparam int HALF = XLEN / 2;
  localparam logic [IW-1:0] SPECIAL = IW'(NREGS);

  logic [XLEN-1:0] gpr [NREGS];
  logic [XLEN-1:0] sp;

  function automatic logic [XLEN-1:0] view(input logic [XLEN-1:0] v, input logic narrow);
    return narrow ? {{HALF{1'b0}}, v[HALF-1:0]} : v;
  endfunction

  logic [XLEN-1:0] a_raw, b_raw;
  always_comb begin
    a_raw = '0;
    b_raw = '0;
    if (rd_a_idx == SPECIAL) a_raw = rd_a_sp ? sp : '0;
    else if (rd_a_idx < SPECIAL) a_raw = gpr[rd_a_idx];
    if (rd_b_idx == SPECIAL) b_raw = rd_b_sp ? sp : '0;
    else if (rd_b_idx < SPECIAL) b_raw = gpr[rd_b_idx];
  end

  assign rd_a_data = view(a_raw, rd_a_narrow);
  assign rd_b_data = view(b_raw, rd_b_narrow);

  logic [XLEN-1:0] wval;
  logic            wr_to_sp;
  assign wval        = view(wr_data, wr_narrow);
  assign wr_to_sp    = wr_en && wr_sp && (wr_idx == SPECIAL);
  assign sp_misalign = wr_to_sp && (|wval[SP_ALIGN-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) gpr[i] <= '0;
      sp <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (link_en && i == LINK_IDX) gpr[i] <= link_addr;
        else if (wr_en && wr_idx == IW'(i)) gpr[i] <= wval;
      end
      if (wr_to_sp && !sp_misalign) sp <= wval;
    end
  end
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int XLEN = 64,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [IW-1:0]   rd_a_idx,
  input logic            rd_a_sp,
  input logic            rd_a_narrow,
  input logic [XLEN-1:0] rd_a_data,
  input logic [IW-1:0]   rd_b_idx,
  input logic            rd_b_narrow,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic [IW-1:0]   wr_idx,
  input logic            wr_narrow,
  input logic [XLEN-1:0] wr_data,
  input logic            link_en,
  input logic [XLEN-1:0] link_addr,
  input logic            sp_misalign
);
  localparam int HALF = XLEN / 2;

  // R2
  narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_narrow |-> rd_a_data[XLEN-1:HALF] == '0);

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 5'd31 && !rd_a_sp) |-> rd_a_data == '0);

  // R1
  full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx < 5'd30 && !wr_narrow) |=>
      ((rd_a_idx == $past(wr_idx) && !rd_a_narrow) -> rd_a_data == $past(wr_data)));

  // R3
  narrow_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx < 5'd30 && wr_narrow) |=>
      ((rd_a_idx == $past(wr_idx) && !rd_a_narrow) ->
        rd_a_data == {{HALF{1'b0}}, $past(wr_data[HALF-1:0])}));

  // R6
  link_write_chk: assert property (@(posedge clk) disable iff (rst)
    link_en |=> ((rd_b_idx == 5'd30 && !rd_b_narrow) -> rd_b_data == $past(link_addr)));

  // R9
  misalign_src_chk: assert property (@(posedge clk) disable iff (rst)
    sp_misalign |-> (wr_en && wr_data[3:0] != 4'd0));
endmodule

bind gpr_file gpr_file_chk #(.XLEN(XLEN), .IW(IW)) u_chk (
  .clk(clk), .rst(rst),
  .rd_a_idx(rd_a_idx), .rd_a_sp(rd_a_sp), .rd_a_narrow(rd_a_narrow), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_narrow(rd_b_narrow), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_narrow(wr_narrow), .wr_data(wr_data),
  .link_en(link_en), .link_addr(link_addr), .sp_misalign(sp_misalign)
);

// File: tb/tb_gpr_file.sv
module tb_gpr_file;
  logic clk = 0;
  logic rst = 1;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic rd_a_sp = 0, rd_a_narrow = 0, rd_b_sp = 0, rd_b_narrow = 0;
  logic wr_en = 0, wr_sp = 0, wr_narrow = 0, link_en = 0;
  logic [63:0] wr_data = 0, link_addr = 0;
  logic [63:0] rd_a_data, rd_b_data;
  logic sp_misalign;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  gpr_file dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_sp(rd_a_sp), .rd_a_narrow(rd_a_narrow), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_sp(rd_b_sp), .rd_b_narrow(rd_b_narrow), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp(wr_sp), .wr_narrow(wr_narrow), .wr_data(wr_data),
    .link_en(link_en), .link_addr(link_addr), .sp_misalign(sp_misalign)
  );

  localparam int NV = 7;
  localparam string       VTAG [NV] = '{"R1", "R3", "R2", "R1", "R3", "R4", "R2"};
  localparam logic [4:0]  VW   [NV] = '{5'd0, 5'd5, 5'd30, 5'd17, 5'd17, 5'd31, 5'd29};
  localparam logic        VWN  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [63:0] VD   [NV] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_DEAD_BEEF,
                                        64'hA5A5_A5A5_5A5A_5A5A, 64'h8000_0000_0000_0001,
                                        64'h1234_5678_8765_4321, 64'hFFFF_FFFF_FFFF_FFFF,
                                        64'hFEDC_BA98_7654_3210};
  localparam logic        VRN  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [63:0] VE   [NV] = '{64'h0123_4567_89AB_CDEF, 64'h0000_0000_DEAD_BEEF,
                                        64'h0000_0000_5A5A_5A5A, 64'h8000_0000_0000_0001,
                                        64'h0000_0000_8765_4321, 64'h0,
                                        64'h0000_0000_7654_3210};

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic sp, input logic nar, input logic [63:0] d);
    wr_en = 1; wr_idx = idx; wr_sp = sp; wr_narrow = nar; wr_data = d;
    step();
    wr_en = 0; wr_sp = 0; wr_narrow = 0;
  endtask

  task automatic rd_a(input logic [4:0] idx, input logic sp, input logic nar);
    rd_a_idx = idx; rd_a_sp = sp; rd_a_narrow = nar;
    #3;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst = 0;
    // R8 reset state
    rd_a(5'd0, 0, 0);   chk("R8 r0 after reset", rd_a_data, 64'h0);
    rd_a(5'd30, 0, 0);  chk("R8 r30 after reset", rd_a_data, 64'h0);
    rd_a(5'd31, 1, 0);  chk("R8 sp after reset", rd_a_data, 64'h0);

    for (int k = 0; k < NV; k++) begin
      wr(VW[k], 1'b0, VWN[k], VD[k]);
      rd_a(VW[k], 1'b0, VRN[k]);
      chk(VTAG[k], rd_a_data, VE[k]);
    end

    // R5 stack pointer via index 31 with stack flag
    wr(5'd31, 1, 0, 64'h0000_0000_0000_1000);
    rd_a(5'd31, 1, 0);  chk("R5 sp read", rd_a_data, 64'h1000);
    rd_a(5'd31, 0, 0);  chk("R5 zero without flag", rd_a_data, 64'h0);
    wr(5'd4, 1, 0, 64'h4444_0000_0000_4444);
    rd_a(5'd4, 0, 0);   chk("R5 flag ignored below 31", rd_a_data, 64'h4444_0000_0000_4444);
    rd_a(5'd31, 1, 0);  chk("R5 sp untouched by r4 write", rd_a_data, 64'h1000);

    // R4 discarded write leaves sp alone
    wr(5'd31, 0, 0, 64'h0000_0000_0000_2000);
    rd_a(5'd31, 1, 0);  chk("R4 sp after zero-reg write", rd_a_data, 64'h1000);
    rd_a(5'd0, 0, 0);   chk("R4 r0 after zero-reg write", rd_a_data, 64'h0123_4567_89AB_CDEF);

    // R9 misaligned sp write
    wr_en = 1; wr_idx = 5'd31; wr_sp = 1; wr_data = 64'h1008;
    #3; chk("R9 flag on misaligned", {63'b0, sp_misalign}, 64'h1);
    step(); wr_en = 0; wr_sp = 0;
    rd_a(5'd31, 1, 0);  chk("R9 sp unchanged", rd_a_data, 64'h1000);
    wr_en = 1; wr_idx = 5'd31; wr_sp = 1; wr_data = 64'hFFFF_0000_0000_3000;
    #3; chk("R9 flag low on aligned", {63'b0, sp_misalign}, 64'h0);
    step(); wr_en = 0; wr_sp = 0;
    rd_a(5'd31, 1, 0);  chk("R9 aligned stored", rd_a_data, 64'hFFFF_0000_0000_3000);

    // R7 no bypass, R10 independent ports
    rd_b_idx = 5'd5; rd_b_narrow = 0;
    wr_en = 1; wr_idx = 5'd3; wr_data = 64'h3333_3333_3333_3333;
    rd_a(5'd3, 0, 0);   chk("R7 old value same cycle", rd_a_data, 64'h0);
    chk("R10 port b independent", rd_b_data, 64'h0000_0000_DEAD_BEEF);
    step(); wr_en = 0;
    #3; chk("R7 new value after edge", rd_a_data, 64'h3333_3333_3333_3333);

    // R6 link write wins over data port on r30
    link_en = 1; link_addr = 64'h0000_7FFF_0000_1234;
    wr_en = 1; wr_idx = 5'd30; wr_data = 64'h9999_9999_9999_9999;
    step(); link_en = 0; wr_en = 0;
    rd_b_idx = 5'd30; #3;
    chk("R6 link address in r30", rd_b_data, 64'h0000_7FFF_0000_1234);

    // R8 reset after registers filled
    rst = 1; step(); rst = 0;
    rd_a(5'd17, 0, 0);  chk("R8 r17 cleared", rd_a_data, 64'h0);
    rd_a(5'd31, 1, 0);  chk("R8 sp cleared", rd_a_data, 64'h0);
    #3; chk("R8 r30 cleared", rd_b_data, 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule